// File: doc/BRIEF.md
# Recent-Flow Write-Through Cache and Memory Port Arbiter

This block connects two clients of a flow table to a single-port main memory with a fixed read latency. The first client is the packet-update side. It either updates an existing flow record by adding an increment, or it creates a new record. The second client is the expiry side. It scans records by reading them and removes flows by clearing them. Only one memory access can happen per clock, so the block grants the port to one client per cycle. When both clients ask in the same cycle, they take turns.

A small fully associative cache holds the flows created most recently. An update whose key is cached never reads memory. Its new record is computed from the cached copy, stored in the cache, and written straight through to memory. An update that misses the cache becomes a memory read. Reads are pipelined, so one can be issued every cycle. Each response returns exactly the read latency after its grant, and returned data is matched to its request by a tag pipeline. Because every cache change is also written to memory, the expiry side always sees current data. A removal also invalidates any cache entry that maps to the removed address.

Top module: `fc_recent_cache`

## Requirements
- R1: Each cycle at most one of `u_req_ready`/`e_req_ready` is high, a ready is high only when its valid is high, and `m_en` is high exactly when one of the two readies is high.
- R2: A lone request is granted in the same cycle. When both request, the client granted less recently wins. After reset the update client wins the first contention.
- R3: An update (`u_req_new`=0) whose key matches a valid cache entry is handled as a hit. It writes the sum of the cached record and `u_req_data` (modulo 2^DW) to the cache and to memory at `u_req_addr`. It issues no read, and it answers with `u_rsp_hit`=1 and that sum.
- R4: An update whose key is not cached issues a memory read at `u_req_addr`. It answers with `u_rsp_hit`=0 and the memory contents.
- R5: Every update and every expiry read gets exactly one response, exactly RD_LAT cycles after its grant, in grant order. At most one response is valid per cycle. Creates and removals give no response.
- R6: A create (`u_req_new`=1) writes `u_req_data` to memory at `u_req_addr`. If the key is already cached, that entry is overwritten in place. Otherwise the slot at a replacement pointer is filled and the pointer advances, wrapping after N_ENT slots.
- R7: An expiry read (`e_req_remove`=0) reads memory at `e_req_addr` and returns the data on `e_rsp_data`.
- R8: An expiry removal (`e_req_remove`=1) writes zero at `e_req_addr` and invalidates every cache entry holding that address. A later update of such a key misses.
- R9: Memory always equals the cached copy of every cached record, so expiry reads of cached flows return the latest updated values.
- R10: After reset the cache is empty, no response is valid, and no memory access is made without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| u_req_valid | input | 1 | Update client request |
| u_req_ready | output | 1 | Update request granted this cycle |
| u_req_new | input | 1 | 1 = create record, 0 = update record |
| u_req_key | input | KW | Flow key |
| u_req_addr | input | AW | Table address of the flow |
| u_req_data | input | DW | Increment (update) or initial record (create) |
| u_rsp_valid | output | 1 | Update response valid |
| u_rsp_hit | output | 1 | Response came from the cache |
| u_rsp_data | output | DW | Updated record (hit) or memory record (miss) |
| e_req_valid | input | 1 | Expiry client request |
| e_req_ready | output | 1 | Expiry request granted this cycle |
| e_req_remove | input | 1 | 1 = remove flow, 0 = read record |
| e_req_addr | input | AW | Table address |
| e_rsp_valid | output | 1 | Expiry read response valid |
| e_rsp_data | output | DW | Record read from memory |
| m_en | output | 1 | Memory access strobe |
| m_we | output | 1 | Memory write enable |
| m_addr | output | AW | Memory address |
| m_wdata | output | DW | Memory write data |
| m_rdata | input | DW | Read data, RD_LAT cycles after the access |

## Verification
The bench goes after the following corner cases:

- **Sustained contention.** Both clients request every cycle. A wrong priority flip would grant one client twice in a row and starve the other.
- **Many keys, few slots.** More keys than cache slots force FIFO eviction. A faulty replacement pointer would make an evicted key still hit, or a fresh key miss.
- **Back-to-back updates to the same key.** A stale cache register would return an old sum.
- **Removal, then re-update.** A remove followed by updates of the same key must turn a hit into a miss. Missing invalidation shows up as a hit with wrong data.
- **Expiry reads of cached flows.** These expose any missing write-through, because memory would hold an old value.
- **Mixed hits and misses.** These check that responses keep the fixed latency and the grant order. A misaligned tag would pair the wrong data with a response.

// File: rtl/fcr_pkg.sv
package fcr_pkg;
  typedef enum logic {
    OWN_UPD = 1'b0,
    OWN_EXP = 1'b1
  } owner_e;

  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_HIT,
    ACC_MISS,
    ACC_NEW,
    ACC_EREAD,
    ACC_ERM
  } access_e;
endpackage

// File: rtl/fcr_arb.sv
module fcr_arb (
  input  logic clk,
  input  logic rst_n,
  input  logic req_u,
  input  logic req_e,
  output logic gnt_u,
  output logic gnt_e
);
  logic turn_e_q, turn_e_d;

  always_comb begin
    gnt_u    = req_u && (!req_e || !turn_e_q);
    gnt_e    = req_e && !gnt_u;
    turn_e_d = turn_e_q;
    if (gnt_u)      turn_e_d = 1'b1;
    else if (gnt_e) turn_e_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) turn_e_q <= 1'b0;
    else        turn_e_q <= turn_e_d;
  end
endmodule

// File: rtl/fcr_cache.sv
module fcr_cache #(
  parameter int N_ENT = 8,
  parameter int KW    = 16,
  parameter int AW    = 6,
  parameter int DW    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KW-1:0]    lk_key,
  input  logic             upd_en,
  input  logic [DW-1:0]    upd_data,
  input  logic             new_en,
  input  logic [AW-1:0]    new_addr,
  input  logic [DW-1:0]    new_data,
  input  logic             inv_en,
  input  logic [AW-1:0]    inv_addr,
  output logic [N_ENT-1:0] hit_vec,
  output logic             hit,
  output logic [DW-1:0]    hit_data
);
  localparam int PW = (N_ENT > 1) ? $clog2(N_ENT) : 1;

  logic [N_ENT-1:0] ent_v, nxt_v;
  logic [KW-1:0]    ent_k [N_ENT];
  logic [KW-1:0]    nxt_k [N_ENT];
  logic [AW-1:0]    ent_a [N_ENT];
  logic [AW-1:0]    nxt_a [N_ENT];
  logic [DW-1:0]    ent_d [N_ENT];
  logic [DW-1:0]    nxt_d [N_ENT];
  logic [PW-1:0]    wptr_q, wptr_d;

  for (genvar g = 0; g < N_ENT; g++) begin : g_cmp
    assign hit_vec[g] = ent_v[g] && (ent_k[g] == lk_key);
  end

  assign hit = |hit_vec;

  always_comb begin
    hit_data = '0;
    for (int i = 0; i < N_ENT; i++) begin
      hit_data = hit_data | ({DW{hit_vec[i]}} & ent_d[i]);
    end
  end

  always_comb begin
    nxt_v  = ent_v;
    wptr_d = wptr_q;
    for (int i = 0; i < N_ENT; i++) begin
      nxt_k[i] = ent_k[i];
      nxt_a[i] = ent_a[i];
      nxt_d[i] = ent_d[i];
      if (upd_en && hit_vec[i]) nxt_d[i] = upd_data;
      if (new_en) begin
        if (hit) begin
          if (hit_vec[i]) begin
            nxt_a[i] = new_addr;
            nxt_d[i] = new_data;
          end
        end else if (wptr_q == PW'(i)) begin
          nxt_v[i] = 1'b1;
          nxt_k[i] = lk_key;
          nxt_a[i] = new_addr;
          nxt_d[i] = new_data;
        end
      end
      if (inv_en && ent_v[i] && (ent_a[i] == inv_addr)) nxt_v[i] = 1'b0;
    end
    if (new_en && !hit) begin
      if (wptr_q == PW'(N_ENT - 1)) wptr_d = '0;
      else                          wptr_d = wptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ent_v  <= '0;
      wptr_q <= '0;
    end else begin
      ent_v  <= nxt_v;
      wptr_q <= wptr_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < N_ENT; i++) begin
      ent_k[i] <= nxt_k[i];
      ent_a[i] <= nxt_a[i];
      ent_d[i] <= nxt_d[i];
    end
  end
endmodule

// File: rtl/fcr_rsp_pipe.sv
module fcr_rsp_pipe
  import fcr_pkg::*;
#(
  parameter int RD_LAT = 4,
  parameter int DW     = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  owner_e        push_own,
  input  logic          push_hit,
  input  logic [DW-1:0] push_data,
  input  logic [DW-1:0] mem_rdata,
  output logic          u_vld,
  output logic          u_hit,
  output logic [DW-1:0] u_data,
  output logic          e_vld,
  output logic [DW-1:0] e_data
);
  localparam int LAST = RD_LAT - 1;

  logic [RD_LAT-1:0] st_v;
  owner_e            st_o [RD_LAT];
  logic [RD_LAT-1:0] st_h;
  logic [DW-1:0]     st_d [RD_LAT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_v <= '0;
    else begin
      st_v[0] <= push;
      for (int i = 1; i < RD_LAT; i++) st_v[i] <= st_v[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (push) begin
      st_o[0] <= push_own;
      st_h[0] <= push_hit;
      st_d[0] <= push_data;
    end
    for (int i = 1; i < RD_LAT; i++) begin
      if (st_v[i-1]) begin
        st_o[i] <= st_o[i-1];
        st_h[i] <= st_h[i-1];
        st_d[i] <= st_d[i-1];
      end
    end
  end

  always_comb begin
    u_vld  = st_v[LAST] && (st_o[LAST] == OWN_UPD);
    e_vld  = st_v[LAST] && (st_o[LAST] == OWN_EXP);
    u_hit  = st_h[LAST];
    u_data = st_h[LAST] ? st_d[LAST] : mem_rdata;
    e_data = mem_rdata;
  end
endmodule

// File: rtl/fc_recent_cache.sv
module fc_recent_cache
  import fcr_pkg::*;
#(
  parameter int KW     = 16,
  parameter int AW     = 6,
  parameter int DW     = 16,
  parameter int N_ENT  = 8,
  parameter int RD_LAT = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          u_req_valid,
  output logic          u_req_ready,
  input  logic          u_req_new,
  input  logic [KW-1:0] u_req_key,
  input  logic [AW-1:0] u_req_addr,
  input  logic [DW-1:0] u_req_data,
  output logic          u_rsp_valid,
  output logic          u_rsp_hit,
  output logic [DW-1:0] u_rsp_data,
  input  logic          e_req_valid,
  output logic          e_req_ready,
  input  logic          e_req_remove,
  input  logic [AW-1:0] e_req_addr,
  output logic          e_rsp_valid,
  output logic [DW-1:0] e_rsp_data,
  output logic          m_en,
  output logic          m_we,
  output logic [AW-1:0] m_addr,
  output logic [DW-1:0] m_wdata,
  input  logic [DW-1:0] m_rdata
);
  logic             gnt_u, gnt_e;
  logic [N_ENT-1:0] hit_vec;
  logic             c_hit;
  logic [DW-1:0]    c_data;
  logic [DW-1:0]    upd_sum;
  access_e          acc;
  logic             rsp_push;
  owner_e           rsp_own;

  fcr_arb i_arb (
    .clk  (clk),
    .rst_n(rst_n),
    .req_u(u_req_valid),
    .req_e(e_req_valid),
    .gnt_u(gnt_u),
    .gnt_e(gnt_e)
  );

  assign u_req_ready = gnt_u;
  assign e_req_ready = gnt_e;
  assign upd_sum     = c_data + u_req_data;

  always_comb begin
    acc = ACC_IDLE;
    if (gnt_u) begin
      if (u_req_new)  acc = ACC_NEW;
      else if (c_hit) acc = ACC_HIT;
      else            acc = ACC_MISS;
    end else if (gnt_e) begin
      acc = e_req_remove ? ACC_ERM : ACC_EREAD;
    end
  end

  always_comb begin
    m_en    = 1'b0;
    m_we    = 1'b0;
    m_addr  = '0;
    m_wdata = '0;
    unique case (acc)
      ACC_HIT:   begin m_en = 1'b1; m_we = 1'b1; m_addr = u_req_addr; m_wdata = upd_sum;    end
      ACC_MISS:  begin m_en = 1'b1;              m_addr = u_req_addr;                       end
      ACC_NEW:   begin m_en = 1'b1; m_we = 1'b1; m_addr = u_req_addr; m_wdata = u_req_data; end
      ACC_EREAD: begin m_en = 1'b1;              m_addr = e_req_addr;                       end
      ACC_ERM:   begin m_en = 1'b1; m_we = 1'b1; m_addr = e_req_addr;                       end
      default:   ;
    endcase
  end

  assign rsp_push = (acc == ACC_HIT) || (acc == ACC_MISS) || (acc == ACC_EREAD);
  assign rsp_own  = (acc == ACC_EREAD) ? OWN_EXP : OWN_UPD;

  fcr_cache #(.N_ENT(N_ENT), .KW(KW), .AW(AW), .DW(DW)) i_cache (
    .clk     (clk),
    .rst_n   (rst_n),
    .lk_key  (u_req_key),
    .upd_en  (acc == ACC_HIT),
    .upd_data(upd_sum),
    .new_en  (acc == ACC_NEW),
    .new_addr(u_req_addr),
    .new_data(u_req_data),
    .inv_en  (acc == ACC_ERM),
    .inv_addr(e_req_addr),
    .hit_vec (hit_vec),
    .hit     (c_hit),
    .hit_data(c_data)
  );

  fcr_rsp_pipe #(.RD_LAT(RD_LAT), .DW(DW)) i_rsp (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (rsp_push),
    .push_own (rsp_own),
    .push_hit (acc == ACC_HIT),
    .push_data(upd_sum),
    .mem_rdata(m_rdata),
    .u_vld    (u_rsp_valid),
    .u_hit    (u_rsp_hit),
    .u_data   (u_rsp_data),
    .e_vld    (e_rsp_valid),
    .e_data   (e_rsp_data)
  );
endmodule

// File: rtl/fc_recent_cache_chk.sv
module fc_recent_cache_chk #(
  parameter int AW    = 6,
  parameter int DW    = 16,
  parameter int N_ENT = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             u_req_valid,
  input logic             u_req_ready,
  input logic             u_req_new,
  input logic [AW-1:0]    u_req_addr,
  input logic             e_req_valid,
  input logic             e_req_ready,
  input logic             e_req_remove,
  input logic             m_en,
  input logic             m_we,
  input logic [AW-1:0]    m_addr,
  input logic [DW-1:0]    m_wdata,
  input logic             u_rsp_valid,
  input logic             e_rsp_valid,
  input logic [N_ENT-1:0] hit_vec
);
  // R1
  ready_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(u_req_ready && e_req_ready));
  // R1
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req_ready |-> u_req_valid) and (e_req_ready |-> e_req_valid));
  // R1
  port_use_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_en |-> (u_req_ready || e_req_ready));
  // R2
  turn_taking_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req_valid && e_req_valid && u_req_ready) |=> (!(u_req_valid && e_req_valid) || e_req_ready));
  // R3
  hit_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req_ready && !u_req_new && (|hit_vec)) |-> (m_en && m_we));
  // R4
  miss_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_req_ready && !u_req_new && !(|hit_vec)) |-> (m_en && !m_we && m_addr == u_req_addr));
  // R6
  unique_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
  // R8
  remove_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (e_req_ready && e_req_remove) |-> (m_we && m_wdata == '0));
  // R5
  one_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(u_rsp_valid && e_rsp_valid));
endmodule

bind fc_recent_cache fc_recent_cache_chk #(.AW(AW), .DW(DW), .N_ENT(N_ENT)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .u_req_valid (u_req_valid),
  .u_req_ready (u_req_ready),
  .u_req_new   (u_req_new),
  .u_req_addr  (u_req_addr),
  .e_req_valid (e_req_valid),
  .e_req_ready (e_req_ready),
  .e_req_remove(e_req_remove),
  .m_en        (m_en),
  .m_we        (m_we),
  .m_addr      (m_addr),
  .m_wdata     (m_wdata),
  .u_rsp_valid (u_rsp_valid),
  .e_rsp_valid (e_rsp_valid),
  .hit_vec     (hit_vec)
);

// File: tb/test_fc_recent_cache.sv
`timescale 1ns/1ps
module test_fc_recent_cache;
  localparam int KW = 16, AW = 6, DW = 16, N = 8, L = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic u_req_valid, u_req_ready, u_req_new;
  logic [KW-1:0] u_req_key;
  logic [AW-1:0] u_req_addr;
  logic [DW-1:0] u_req_data;
  logic u_rsp_valid, u_rsp_hit;
  logic [DW-1:0] u_rsp_data;
  logic e_req_valid, e_req_ready, e_req_remove;
  logic [AW-1:0] e_req_addr;
  logic e_rsp_valid;
  logic [DW-1:0] e_rsp_data;
  logic m_en, m_we;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;

  always #2.5 clk = ~clk;

  fc_recent_cache #(.KW(KW), .AW(AW), .DW(DW), .N_ENT(N), .RD_LAT(L)) i_fc_recent_cache (.*);

  // memory fixture: one port, L-cycle read latency
  logic [DW-1:0] mem [2**AW];
  logic [DW-1:0] rp  [L];
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 2**AW; k++) mem[k] <= '0;
    end else if (m_en && m_we) mem[m_addr] <= m_wdata;
    rp[0] <= mem[m_addr];
    for (int k = 1; k < L; k++) rp[k] <= rp[k-1];
  end
  assign m_rdata = rp[L-1];

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  typedef struct {int due; bit own; bit hit; logic [DW-1:0] d;} exp_t;
  exp_t q[$];

  // reference state
  bit            mv [N];
  logic [KW-1:0] mk [N];
  logic [AW-1:0] ma [N];
  logic [DW-1:0] md [N];
  logic [DW-1:0] mm [2**AW];
  int            mptr = 0;
  bit            mprio = 0;

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) mv[i] = 0;
    for (int i = 0; i < 2**AW; i++) mm[i] = '0;
    rst_n = 0;
    u_req_valid = 0; u_req_new = 0; u_req_key = '0; u_req_addr = '0; u_req_data = '0;
    e_req_valid = 0; e_req_remove = 0; e_req_addr = '0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    // R10: idle after reset
    chk(!u_req_ready && !e_req_ready, "R10 ready", {u_req_ready, e_req_ready}, 0);
    chk(!u_rsp_valid && !e_rsp_valid, "R10 rsp", {u_rsp_valid, e_rsp_valid}, 0);
    chk(!m_en, "R10 m_en", m_en, 0);

    for (int cyc = 0; cyc < 3000 + L + 2; cyc++) begin
      int hi;
      bit gu, ge, e_en, e_we;
      logic [AW-1:0] e_addr;
      logic [DW-1:0] e_wd, sum;
      string tag;
      @(negedge clk);
      if (cyc < 3000) begin
        int key;
        key = $urandom_range(0, 11);
        u_req_valid  = (cyc < 300) ? 1'b1 : ($urandom_range(0, 9) < 6);
        e_req_valid  = (cyc < 300) ? 1'b1 : ($urandom_range(0, 9) < 4);
        u_req_new    = ($urandom_range(0, 99) < 35);
        u_req_key    = KW'(key);
        u_req_addr   = AW'(key);
        u_req_data   = DW'($urandom_range(0, 65535));
        e_req_remove = ($urandom_range(0, 99) < 25);
        e_req_addr   = AW'($urandom_range(0, 11));
      end else begin
        u_req_valid = 0;
        e_req_valid = 0;
      end
      #1;
      hi = -1;
      for (int i = 0; i < N; i++) if (mv[i] && mk[i] == u_req_key) hi = i;
      gu = u_req_valid && (!e_req_valid || !mprio);
      ge = e_req_valid && !gu;
      e_en = gu || ge; e_we = 0; e_addr = '0; e_wd = '0; sum = '0; tag = "R1";
      if (gu) begin
        e_addr = u_req_addr;
        if (u_req_new) begin e_we = 1; e_wd = u_req_data; tag = "R6"; end
        else if (hi >= 0) begin sum = md[hi] + u_req_data; e_we = 1; e_wd = sum; tag = "R3"; end
        else tag = "R4";
      end else if (ge) begin
        e_addr = e_req_addr;
        if (e_req_remove) begin e_we = 1; tag = "R8"; end
        else tag = "R7";
      end
      chk(u_req_ready == gu, "R2 u_ready", u_req_ready, gu);
      chk(e_req_ready == ge, "R2 e_ready", e_req_ready, ge);
      chk(m_en == e_en, "R1 m_en", m_en, e_en);
      if (e_en) begin
        chk(m_we == e_we, tag, m_we, e_we);
        chk(m_addr == e_addr, tag, m_addr, e_addr);
        if (e_we) chk(m_wdata == e_wd, tag, m_wdata, e_wd);
      end
      if (q.size() > 0 && q[0].due == cyc) begin
        exp_t e;
        e = q.pop_front();
        if (!e.own) begin
          chk(u_rsp_valid && !e_rsp_valid, "R5 u_rsp", {u_rsp_valid, e_rsp_valid}, 2);
          chk(u_rsp_hit == e.hit, "R3 R4 R6 R8 hit", u_rsp_hit, e.hit);
          chk(u_rsp_data == e.d, e.hit ? "R3 data" : "R4 data", u_rsp_data, e.d);
        end else begin
          chk(e_rsp_valid && !u_rsp_valid, "R5 e_rsp", {e_rsp_valid, u_rsp_valid}, 2);
          chk(e_rsp_data == e.d, "R7 R9 data", e_rsp_data, e.d);
        end
      end else begin
        chk(!u_rsp_valid && !e_rsp_valid, "R5 idle", {u_rsp_valid, e_rsp_valid}, 0);
      end
      // reference update for this clock edge
      if (gu) begin
        if (!u_req_new) begin
          if (hi >= 0) begin
            md[hi] = sum;
            mm[u_req_addr] = sum;
            q.push_back('{cyc + L, 1'b0, 1'b1, sum});
          end else q.push_back('{cyc + L, 1'b0, 1'b0, mm[u_req_addr]});
        end else begin
          mm[u_req_addr] = u_req_data;
          if (hi >= 0) begin
            ma[hi] = u_req_addr;
            md[hi] = u_req_data;
          end else begin
            mv[mptr] = 1; mk[mptr] = u_req_key; ma[mptr] = u_req_addr; md[mptr] = u_req_data;
            mptr = (mptr + 1) % N;
          end
        end
        mprio = 1;
      end
      if (ge) begin
        if (e_req_remove) begin
          mm[e_req_addr] = '0;
          for (int i = 0; i < N; i++) if (mv[i] && ma[i] == e_req_addr) mv[i] = 0;
        end else q.push_back('{cyc + L, 1'b1, 1'b0, mm[e_req_addr]});
        mprio = 0;
      end
    end
    chk(q.size() == 0, "R5 drained", q.size(), 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule